// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block sits behind the line decoder of an Ethernet receiver. It takes NRZ bytes qualified by a byte strobe and a frame-active level. It discards the run of preamble bytes and the start-of-frame delimiter. It then collects the six destination address bytes and classifies the destination as the station's own address, broadcast, multicast or another unicast address. The per-class accept enables, plus an accept-everything mode, decide whether the frame is kept.

Kept frames are written byte by byte into a circular receive buffer, starting at the buffer head. The head is the first free location, and the reader of the buffer uses it. The CRC-32 runs over every byte after the delimiter, including the frame check sequence. When frame-active drops, the block publishes a one-cycle status word and moves the head past the frame. The status word carries the length, the CRC-error flag, the runt flag and the address class. An event pulse goes with the status word for good frames, and also for CRC-damaged frames when configured.

Frames that are refused, cut short inside the address or malformed before the delimiter leave the head where it was. Any address bytes already written for them are therefore overwritten by the next frame.

The controller has five states. ST_IDLE waits for the first byte. ST_PRE consumes preamble bytes. ST_ADDR collects the destination. ST_DATA stores an accepted frame. ST_DROP waits out a refused or malformed frame.

The transitions are as follows:
- idle-to-addr: the delimiter arrives with no preamble.
- idle-to-pre: a preamble byte arrives.
- idle-to-drop: any other first byte arrives.
- pre-to-pre: a further preamble byte arrives.
- pre-to-addr: the delimiter arrives.
- pre-to-drop: any other byte arrives.
- pre-to-idle: frame-active falls.
- addr-to-data: the sixth address byte arrives and the filter accepts.
- addr-to-drop: the sixth address byte arrives and the filter refuses.
- addr-to-idle: an abort, when frame-active falls early.
- data-to-idle: the report, when frame-active falls.
- drop-to-idle: frame-active falls.

Top module: `eth_rx_filter`

## Requirements
- R1: Before the frame, bytes 0x55 are skipped and 0xD5 starts the frame. Neither is ever written to the buffer, so the first buffer byte of a kept frame is destination byte 0. If the first byte that is neither 0x55 nor 0xD5 arrives before 0xD5, the frame is dropped with no status.
- R2: Bytes of a kept frame are written in arrival order. The first byte goes to the head, and each following byte goes to the next address, modulo the buffer depth. Each write appears on the write port one cycle after the byte is sampled.
- R3: Destination byte k is compared with stn_addr[8k+7:8k]. A frame is kept when one of these holds: it equals the station address and acc_unicast=1; it is all ones and acc_bcast=1; or bit 0 of destination byte 0 is set, it is not all ones, and acc_mcast=1. A broadcast frame is never kept through acc_mcast.
- R4: With acc_all=1, every frame with a complete destination is kept, whatever the other enables say.
- R5: A refused frame, or one whose frame-active falls before the sixth address byte, produces no stat_valid and no frame_evt, and leaves buf_head unchanged.
- R6: After a kept frame, buf_head equals its value before the frame plus the frame length, modulo the buffer depth. The head changes only together with stat_valid.
- R7: The cycle after frame-active falls on a kept frame, stat_valid pulses for exactly one cycle. stat_len then counts the bytes from destination byte 0 through the last FCS byte. stat_reason gives the destination class: 0 for other unicast, 1 for station match, 2 for broadcast, 3 for multicast. The class is reported even when acc_all alone kept the frame.
- R8: stat_crc_err is 1 exactly when the CRC-32 over destination through FCS does not match. The CRC uses polynomial 0x04C11DB7, reflected, with the register preset to all ones and the FCS sent low byte first and inverted.
- R9: stat_runt is 1 exactly when stat_len is below 64.
- R10: frame_evt pulses with stat_valid for every kept frame without a CRC error. For a kept frame with a CRC error, it pulses only when evt_on_crc_err=1. frame_evt never pulses without stat_valid.
- R11: After reset, buf_we, stat_valid and frame_evt are 0 and buf_head is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_active | input | 1 | High for the duration of a received frame |
| rx_valid | input | 1 | rx_data holds a byte this cycle |
| rx_data | input | 8 | Decoded receive byte |
| stn_addr | input | 48 | Station address, byte k in bits 8k+7:8k |
| acc_unicast | input | 1 | Keep frames addressed to the station |
| acc_bcast | input | 1 | Keep broadcast frames |
| acc_mcast | input | 1 | Keep multicast frames |
| acc_all | input | 1 | Keep every frame |
| evt_on_crc_err | input | 1 | Also raise the event for frames with a CRC error |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | AW | Buffer write address |
| buf_wdata | output | 8 | Buffer write data |
| buf_head | output | AW | First free buffer location after the last kept frame |
| stat_valid | output | 1 | One-cycle status strobe |
| stat_len | output | LW | Frame length in bytes |
| stat_crc_err | output | 1 | CRC check failed |
| stat_runt | output | 1 | Frame shorter than 64 bytes |
| stat_reason | output | 2 | Destination class |
| frame_evt | output | 1 | Frame-received event |

## Verification
The properties assume the following about the inputs:
- rx_valid is raised only while rx_active is high.
- The configuration inputs change only while no frame is in progress.
- No frame reaches the saturation value of the length counter.

The head-advance property also assumes that a frame never spans more than the buffer depth in a way that matters for modular arithmetic, since it compares lengths modulo the depth.

The bench respects all of this. It drives bytes only inside a frame window and changes the enables only during the idle gap between frames. Its frames stay below 90 bytes against a 128-entry buffer. Within those limits it varies the preamble length, inserts strobe gaps, and lets the head wrap several times.

// File: rtl/eth_rxf_pkg.sv
package eth_rxf_pkg;

    localparam logic [7:0] PRE_BYTE   = 8'h55;
    localparam logic [7:0] SFD_BYTE   = 8'hD5;
    localparam int         ADDR_BYTES = 6;
    localparam logic [31:0] CRC_POLY  = 32'hEDB88320;
    localparam logic [31:0] CRC_RESID = 32'hDEBB20E3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ADDR,
        ST_DATA,
        ST_DROP
    } rxf_state_e;

    typedef enum logic [1:0] {
        DC_OTHER = 2'd0,
        DC_UNI   = 2'd1,
        DC_BCAST = 2'd2,
        DC_MCAST = 2'd3
    } dest_class_e;

endpackage

// File: rtl/eth_rxf_crc32.sv
module eth_rxf_crc32
    import eth_rxf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init,
    input  logic       en,
    input  logic [7:0] data,
    output logic       crc_ok
);

    logic [31:0] crc_q;
    logic [31:0] crc_next;

    always_comb begin
        crc_next = crc_q;
        for (int i = 0; i < 8; i++) begin
            if (crc_next[0] ^ data[i])
                crc_next = {1'b0, crc_next[31:1]} ^ CRC_POLY;
            else
                crc_next = {1'b0, crc_next[31:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            crc_q <= '1;
        else if (init)
            crc_q <= '1;
        else if (en)
            crc_q <= crc_next;
    end

    assign crc_ok = (crc_q == CRC_RESID);

endmodule

// File: rtl/eth_rxf_classify.sv
module eth_rxf_classify
    import eth_rxf_pkg::*;
(
    input  logic [47:0]  dst,
    input  logic [47:0]  stn,
    input  logic         en_uni,
    input  logic         en_bc,
    input  logic         en_mc,
    input  logic         en_all,
    output logic         pass,
    output dest_class_e  cls
);

    logic [ADDR_BYTES-1:0] byte_eq;
    logic [ADDR_BYTES-1:0] byte_ones;

    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_byte
        assign byte_eq[k]   = (dst[8*k +: 8] == stn[8*k +: 8]);
        assign byte_ones[k] = (dst[8*k +: 8] == 8'hFF);
    end

    logic is_uni, is_bc, is_mc;

    assign is_uni = &byte_eq;
    assign is_bc  = &byte_ones;
    assign is_mc  = dst[0] && !is_bc;

    always_comb begin
        if (is_bc)
            cls = DC_BCAST;
        else if (is_mc)
            cls = DC_MCAST;
        else if (is_uni)
            cls = DC_UNI;
        else
            cls = DC_OTHER;
    end

    assign pass = en_all
                | (is_uni & en_uni)
                | (is_bc  & en_bc)
                | (is_mc  & en_mc);

endmodule

// File: rtl/eth_rx_filter.sv
module eth_rx_filter
    import eth_rxf_pkg::*;
#(
    parameter int AW      = 10,
    parameter int LW      = 11,
    parameter int MIN_LEN = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_active,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic [47:0]   stn_addr,
    input  logic          acc_unicast,
    input  logic          acc_bcast,
    input  logic          acc_mcast,
    input  logic          acc_all,
    input  logic          evt_on_crc_err,
    output logic          buf_we,
    output logic [AW-1:0] buf_addr,
    output logic [7:0]    buf_wdata,
    output logic [AW-1:0] buf_head,
    output logic          stat_valid,
    output logic [LW-1:0] stat_len,
    output logic          stat_crc_err,
    output logic          stat_runt,
    output logic [1:0]    stat_reason,
    output logic          frame_evt
);

    localparam logic [LW-1:0] ADDR_LAST = LW'(ADDR_BYTES - 1);
    localparam logic [LW-1:0] RUNT_LIM  = LW'(MIN_LEN);
    localparam logic [LW-1:0] LEN_MAX   = '1;

    rxf_state_e    state_q, state_d;
    logic [LW-1:0] len_q;
    logic [AW-1:0] cur_q;
    logic [AW-1:0] head_q;
    logic [47:0]   dst_q;
    dest_class_e   cls_q;

    logic          byte_in;
    logic          is_sfd, is_pre;
    logic          hunting;
    logic          storing;
    logic          last_addr;
    logic          sfd_hit;
    logic          report;
    logic [47:0]   dst_full;
    logic          flt_pass;
    dest_class_e   flt_cls;
    logic          crc_ok;

    assign byte_in   = rx_active && rx_valid;
    assign is_sfd    = (rx_data == SFD_BYTE);
    assign is_pre    = (rx_data == PRE_BYTE);
    assign hunting   = (state_q == ST_IDLE) || (state_q == ST_PRE);
    assign storing   = (state_q == ST_ADDR) || (state_q == ST_DATA);
    assign last_addr = (state_q == ST_ADDR) && byte_in && (len_q == ADDR_LAST);
    assign sfd_hit   = hunting && byte_in && is_sfd;
    assign report    = (state_q == ST_DATA) && !rx_active;
    assign dst_full  = {rx_data, dst_q[47:8]};

    eth_rxf_classify u_cls (
        .dst    (dst_full),
        .stn    (stn_addr),
        .en_uni (acc_unicast),
        .en_bc  (acc_bcast),
        .en_mc  (acc_mcast),
        .en_all (acc_all),
        .pass   (flt_pass),
        .cls    (flt_cls)
    );

    eth_rxf_crc32 u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (sfd_hit),
        .en     (storing && byte_in),
        .data   (rx_data),
        .crc_ok (crc_ok)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (byte_in) begin
                    if (is_sfd)      state_d = ST_ADDR;
                    else if (is_pre) state_d = ST_PRE;
                    else             state_d = ST_DROP;
                end
            end
            ST_PRE: begin
                if (!rx_active)        state_d = ST_IDLE;
                else if (byte_in) begin
                    if (is_sfd)       state_d = ST_ADDR;
                    else if (!is_pre) state_d = ST_DROP;
                end
            end
            ST_ADDR: begin
                if (!rx_active)     state_d = ST_IDLE;
                else if (last_addr) state_d = flt_pass ? ST_DATA : ST_DROP;
            end
            ST_DATA: begin
                if (!rx_active) state_d = ST_IDLE;
            end
            ST_DROP: begin
                if (!rx_active) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q        <= '0;
            cur_q        <= '0;
            head_q       <= '0;
            dst_q        <= '0;
            cls_q        <= DC_OTHER;
            buf_we       <= 1'b0;
            buf_addr     <= '0;
            buf_wdata    <= '0;
            stat_valid   <= 1'b0;
            stat_len     <= '0;
            stat_crc_err <= 1'b0;
            stat_runt    <= 1'b0;
            stat_reason  <= '0;
            frame_evt    <= 1'b0;
        end else begin
            buf_we     <= 1'b0;
            stat_valid <= 1'b0;
            frame_evt  <= 1'b0;

            if (sfd_hit) begin
                len_q <= '0;
                cur_q <= head_q;
            end

            if (storing && byte_in) begin
                buf_we    <= 1'b1;
                buf_addr  <= cur_q;
                buf_wdata <= rx_data;
                cur_q     <= cur_q + 1'b1;
                if (len_q != LEN_MAX)
                    len_q <= len_q + 1'b1;
                if (state_q == ST_ADDR)
                    dst_q <= dst_full;
            end

            if (last_addr)
                cls_q <= flt_cls;

            if (report) begin
                stat_valid   <= 1'b1;
                stat_len     <= len_q;
                stat_crc_err <= !crc_ok;
                stat_runt    <= (len_q < RUNT_LIM);
                stat_reason  <= cls_q;
                frame_evt    <= crc_ok || evt_on_crc_err;
                head_q       <= cur_q;
            end
        end
    end

    assign buf_head = head_q;

endmodule

// File: rtl/eth_rx_filter_chk.sv
module eth_rx_filter_chk #(
    parameter int AW      = 10,
    parameter int LW      = 11,
    parameter int MIN_LEN = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          buf_we,
    input logic [AW-1:0] buf_addr,
    input logic [AW-1:0] buf_head,
    input logic          stat_valid,
    input logic [LW-1:0] stat_len,
    input logic          stat_crc_err,
    input logic          stat_runt,
    input logic          frame_evt
);

    // R10
    evt_with_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_evt |-> stat_valid);

    // R10
    good_frame_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && !stat_crc_err) |-> frame_evt);

    // R6
    head_only_on_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_head != $past(buf_head)) |-> stat_valid);

    // R6
    head_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && (stat_len != '1)) |->
            (buf_head == AW'($past(buf_head) + AW'(stat_len))));

    // R7
    stat_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> !stat_valid);

    // R7
    stat_len_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> (stat_len >= LW'(6)));

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && $past(buf_we)) |-> (buf_addr == AW'($past(buf_addr) + 1'b1)));

    // R9
    runt_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && (stat_len >= LW'(MIN_LEN))) |-> !stat_runt);

endmodule

bind eth_rx_filter eth_rx_filter_chk #(.AW(AW), .LW(LW), .MIN_LEN(MIN_LEN)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .buf_we       (buf_we),
    .buf_addr     (buf_addr),
    .buf_head     (buf_head),
    .stat_valid   (stat_valid),
    .stat_len     (stat_len),
    .stat_crc_err (stat_crc_err),
    .stat_runt    (stat_runt),
    .frame_evt    (frame_evt)
);

// File: tb/eth_rx_filter_tb_top.sv
module eth_rx_filter_tb_top;

    localparam int AW = 7;
    localparam int LW = 11;
    localparam int DEPTH = 1 << AW;
    localparam logic [47:0] STN = 48'h554433221102;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_active = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = 8'h00;
    logic          acc_unicast = 1'b0, acc_bcast = 1'b0, acc_mcast = 1'b0;
    logic          acc_all = 1'b0, evt_on_crc_err = 1'b0;
    logic          buf_we;
    logic [AW-1:0] buf_addr;
    logic [7:0]    buf_wdata;
    logic [AW-1:0] buf_head;
    logic          stat_valid;
    logic [LW-1:0] stat_len;
    logic          stat_crc_err, stat_runt;
    logic [1:0]    stat_reason;
    logic          frame_evt;

    always #4 clk = ~clk;

    eth_rx_filter #(.AW(AW), .LW(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_active(rx_active), .rx_valid(rx_valid),
        .rx_data(rx_data), .stn_addr(STN), .acc_unicast(acc_unicast),
        .acc_bcast(acc_bcast), .acc_mcast(acc_mcast), .acc_all(acc_all),
        .evt_on_crc_err(evt_on_crc_err), .buf_we(buf_we), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .buf_head(buf_head), .stat_valid(stat_valid),
        .stat_len(stat_len), .stat_crc_err(stat_crc_err), .stat_runt(stat_runt),
        .stat_reason(stat_reason), .frame_evt(frame_evt)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // frame image (destination through FCS)
    logic [7:0] fr [0:127];
    int fr_len = 0;

    // monitor
    int  wr_n = 0, mism = 0, first_addr = 0;
    bit  got_stat = 0;
    int  st_len = 0, st_rsn = 0;
    bit  st_crc = 0, st_runt = 0, st_evt = 0;
    int  evt_seen = 0;

    always @(negedge clk) begin
        if (buf_we) begin
            if (wr_n == 0) first_addr = int'(buf_addr);
            if (wr_n < 128 && buf_wdata != fr[wr_n]) mism++;
            wr_n++;
        end
        if (frame_evt) evt_seen++;
        if (stat_valid) begin
            got_stat = 1;
            st_len  = int'(stat_len);
            st_crc  = stat_crc_err;
            st_runt = stat_runt;
            st_rsn  = int'(stat_reason);
            st_evt  = frame_evt;
        end
    end

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int k = 0; k < 8; k++)
            r = ((r[0] ^ b[k]) != 1'b0) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    task automatic build(input int kind, input int pay, input bit bad, input int seed);
        logic [31:0] c;
        logic [7:0] d [0:5];
        for (int k = 0; k < 6; k++) begin
            case (kind)
                0: d[k] = STN[8*k +: 8];
                1: d[k] = 8'hFF;
                2: d[k] = (k == 0) ? 8'h01 : (k == 2) ? 8'h5E : (k == 5) ? 8'hFB : 8'h00;
                default: d[k] = (k == 5) ? 8'h56 : STN[8*k +: 8];
            endcase
            fr[k] = d[k];
            fr[6 + k] = 8'hA0 + 8'(k);
        end
        for (int j = 0; j < pay; j++) fr[12 + j] = 8'((seed * 7 + j) & 255);
        fr_len = 12 + pay;
        c = 32'hFFFFFFFF;
        for (int j = 0; j < fr_len; j++) c = crc_byte(c, fr[j]);
        c = ~c;
        for (int k = 0; k < 4; k++) fr[fr_len + k] = c[8*k +: 8];
        if (bad) fr[fr_len] = fr[fr_len] ^ 8'h01;
        fr_len = fr_len + 4;
    endtask

    task automatic put(input logic [7:0] b);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // send the prepared image; nbytes limits how much of it goes out
    task automatic send(input int pre_n, input bit gap, input bit junk, input int nbytes);
        @(negedge clk);
        wr_n = 0; mism = 0; got_stat = 0; evt_seen = 0;
        rx_active = 1'b1;
        if (junk) put(8'hA5);
        for (int p = 0; p < pre_n; p++) put(8'h55);
        put(8'hD5);
        for (int j = 0; j < nbytes; j++) begin
            if (gap && j == 10) @(negedge clk);
            put(fr[j]);
        end
        rx_active = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // [23:22] kind [21:16] payload [15] bad fcs [14:10] ui,bc,mc,all,evt_on_err
    // [9] expect kept [8:7] expect class [6] expect event
    function automatic logic [23:0] mkv(input int kind, input int pay, input bit bad,
        input bit ui, input bit bc, input bit mc, input bit al, input bit nb,
        input bit acc, input int rsn, input bit evt);
        return {2'(kind), 6'(pay), bad, ui, bc, mc, al, nb, acc, 2'(rsn), evt, 6'd0};
    endfunction

    localparam int NV = 13;
    localparam logic [23:0] VEC [0:NV-1] = '{
        mkv(0, 50, 0, 1, 1, 1, 0, 0, 1, 1, 1),
        mkv(1, 46, 0, 1, 1, 1, 0, 0, 1, 2, 1),
        mkv(2, 45, 0, 1, 1, 1, 0, 0, 1, 3, 1),
        mkv(3, 50, 0, 1, 1, 1, 0, 0, 0, 0, 0),
        mkv(3, 40, 0, 0, 0, 0, 1, 0, 1, 0, 1),
        mkv(1, 50, 0, 1, 0, 1, 0, 0, 0, 0, 0),
        mkv(2, 50, 0, 1, 1, 0, 0, 0, 0, 0, 0),
        mkv(0, 50, 0, 0, 1, 1, 0, 0, 0, 0, 0),
        mkv(0, 50, 1, 1, 0, 0, 0, 0, 1, 1, 0),
        mkv(0, 47, 1, 1, 0, 0, 0, 1, 1, 1, 1),
        mkv(0, 50, 0, 0, 0, 0, 1, 0, 1, 1, 1),
        mkv(2, 60, 1, 0, 0, 0, 1, 0, 1, 3, 0),
        mkv(3, 20, 1, 0, 0, 0, 1, 1, 1, 0, 1)
    };

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int exp_head;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(buf_we == 1'b0, "R11 buf_we", int'(buf_we), 0);
        chk(stat_valid == 1'b0, "R11 stat_valid", int'(stat_valid), 0);
        chk(frame_evt == 1'b0, "R11 frame_evt", int'(frame_evt), 0);
        chk(buf_head == '0, "R11 buf_head", int'(buf_head), 0);
        exp_head = 0;

        for (int i = 0; i < NV; i++) begin
            logic [23:0] v;
            bit acc;
            v = VEC[i];
            acc = v[9];
            build(int'(v[23:22]), int'(v[21:16]), v[15], i);
            {acc_unicast, acc_bcast, acc_mcast, acc_all, evt_on_crc_err} = v[14:10];
            send((i % 3) * 3, i[0], 1'b0, fr_len);
            chk(got_stat == acc, "R3 R4 kept", int'(got_stat), int'(acc));
            if (acc) begin
                chk(st_len == fr_len, "R7 length", st_len, fr_len);
                chk(st_rsn == int'(v[8:7]), "R7 class", st_rsn, int'(v[8:7]));
                chk(st_runt == (fr_len < 64), "R9 runt", int'(st_runt), int'(fr_len < 64));
                chk(st_crc == v[15], "R8 crc flag", int'(st_crc), int'(v[15]));
                chk(st_evt == v[6] && evt_seen == int'(v[6]), "R10 event", evt_seen, int'(v[6]));
                chk(wr_n == fr_len && mism == 0, "R1 stored bytes", mism, 0);
                chk(first_addr == exp_head, "R2 start address", first_addr, exp_head);
                exp_head = (exp_head + fr_len) % DEPTH;
                chk(int'(buf_head) == exp_head, "R6 head", int'(buf_head), exp_head);
            end else begin
                chk(int'(buf_head) == exp_head, "R5 head kept", int'(buf_head), exp_head);
                chk(evt_seen == 0, "R5 no event", evt_seen, 0);
            end
        end

        // R5: frame-active falls inside the destination address
        {acc_unicast, acc_bcast, acc_mcast, acc_all, evt_on_crc_err} = 5'b11110;
        build(0, 50, 0, 99);
        send(7, 0, 0, 3);
        chk(got_stat == 0, "R5 abort status", int'(got_stat), 0);
        chk(int'(buf_head) == exp_head, "R5 abort head", int'(buf_head), exp_head);

        // R1: stray byte before the delimiter drops the frame
        send(2, 0, 1, fr_len);
        chk(got_stat == 0, "R1 stray byte status", int'(got_stat), 0);
        chk(wr_n == 0, "R1 stray byte writes", wr_n, 0);
        chk(int'(buf_head) == exp_head, "R1 stray byte head", int'(buf_head), exp_head);

        // R2: a following good frame lands at the unchanged head
        send(7, 0, 0, fr_len);
        chk(got_stat == 1 && first_addr == exp_head, "R2 after drops", first_addr, exp_head);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule